// File: doc/BRIEF.md
# DRAM Open-Row RAS Controller

This block is the row-management sequencer of a DRAM bus controller. For each DRAM access it decides whether the open row can be reused, in which case only a column cycle is run as a fast-page burst. Otherwise it precharges, activates the new row and then runs the column cycle. It drives the active-low row strobe, the active-low column strobe, the row/column address-mux select and a multiplexed address, and it gives a one-cycle completion pulse.

Two configuration bits decide whether a row is kept open after an access. Keep-open mode is active only when both the burst-enable bit and the row-hold bit are set. In this mode the row strobe stays low while the bus serves other, non-DRAM address spaces. A later access to the same row then continues the burst with no new activation. Refresh, self-refresh entry, standby entry, release of the bus to an outside requester, or clearing either configuration bit closes the row. A clock-stop request does not close the row: the strobe stays low and no new request is taken.

When keep-open mode is off, the row strobe returns high after every access. The precharge time before a new row is opened is programmable and is at least one cycle.

Top module: `dram_row_ctrl`

## Requirements
- R1: After reset ras_n=1, cas_n=1, done=0, addr_sel=0 and req_ready=1.
- R2: Keep-open mode = cfg_burst_en AND cfg_ras_down. When it is off (including cfg_burst_en=0 with cfg_ras_down=1), ras_n is 1 in the cycle after the done pulse.
- R3: In keep-open mode, an accepted access whose row equals the open row runs no activation. ras_n stays 0, and done and cas_n=0 appear in the cycle right after acceptance.
- R4: An accepted access to a different row while a row is open holds ras_n=1 for max(cfg_precharge,1) cycles. One activation cycle follows (ras_n=0, cas_n=1, addr_sel=0, addr_out=row), then the column cycle.
- R5: An access accepted with no row open runs one activation cycle immediately (addr_out=row), then the column cycle. done comes two cycles after acceptance.
- R6: While a row is held open and other_space=1, ras_n stays 0 and req_ready is 0.
- R7: With a row open, a 1 on ev_refresh, ev_self_refresh, ev_standby or ev_bus_release drives ras_n to 1 in the next cycle. The open row is forgotten, so the next access does a full activation.
- R8: With a row open, clearing cfg_burst_en or cfg_ras_down drives ras_n to 1 in the next cycle.
- R9: While ev_clock_stop=1, req_ready is 0, and a held row stays open with ras_n=0. A same-row access afterwards is a fast-page hit.
- R10: done is a single-cycle pulse that coincides with cas_n=0, ras_n=0, addr_sel=1 and addr_out equal to the access's column, zero-extended.
- R11: A close event that arrives while an access is in progress does not abort it. The column cycle and done still occur, and the event is applied when the column cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | DRAM-space access request |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| other_space | input | 1 | Bus is busy with a non-DRAM space access |
| cfg_burst_en | input | 1 | Burst (fast-page) enable bit |
| cfg_ras_down | input | 1 | Row-hold bit, effective only with cfg_burst_en |
| cfg_precharge | input | PRE_W | Precharge cycles before a new row (0 acts as 1) |
| ev_refresh | input | 1 | Refresh cycle request |
| ev_self_refresh | input | 1 | Self-refresh entry |
| ev_standby | input | 1 | Software standby entry |
| ev_bus_release | input | 1 | Bus granted to an outside requester |
| ev_clock_stop | input | 1 | Module clock-stop request |
| req_ready | output | 1 | Request can be accepted this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_sel | output | 1 | Address mux select: 0 row, 1 column |
| addr_out | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume req_valid only matters when req_ready is high. They also assume the request's row is stable in the cycle it is accepted, and that the event inputs are free to change in any cycle. The stimulus drives every input at the falling edge. It raises req_valid only after it has seen req_ready high, and it drops req_valid right after acceptance. A close event is injected in the middle of an access only through the dedicated case that exercises R11. The configuration bits change only while the sequencer is idle or holding a row.

// File: rtl/dram_row_pkg.sv
package dram_row_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ACT  = 3'd2,
    ST_COL  = 3'd3,
    ST_HOLD = 3'd4
  } seq_state_e;

  // keep-open mode needs both bits
  function automatic logic keep_open(input logic burst_en, input logic ras_down);
    return burst_en & ras_down;
  endfunction

  // events that force the row closed; clock stop is deliberately absent
  function automatic logic close_cause(input logic refresh, input logic self_ref,
                                       input logic standby, input logic bus_rel,
                                       input logic mode_on);
    return refresh | self_ref | standby | bus_rel | ~mode_on;
  endfunction

endpackage

// File: rtl/drr_row_tracker.sv
module drr_row_tracker #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] new_row,
  input  logic             set_valid,
  input  logic             clr_valid,
  output logic [ROW_W-1:0] open_row,
  output logic             row_valid,
  output logic             row_hit
);

  function automatic logic same_row(input logic v, input logic [ROW_W-1:0] a,
                                    input logic [ROW_W-1:0] b);
    return v && (a == b);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_row  <= '0;
      row_valid <= 1'b0;
    end else begin
      if (load) open_row <= new_row;
      if (clr_valid)      row_valid <= 1'b0;
      else if (set_valid) row_valid <= 1'b1;
    end
  end

  assign row_hit = same_row(row_valid, open_row, new_row);

  // R7: a cleared row stays invalid until an activation sets it again
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> !row_valid);

endmodule

// File: rtl/drr_pre_timer.sv
module drr_pre_timer #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PRE_W-1:0] trp,
  input  logic             run,
  output logic             expired
);

  // a zero setting still gives one cycle of precharge
  function automatic logic [PRE_W-1:0] eff_len(input logic [PRE_W-1:0] t);
    return (t == '0) ? PRE_W'(1) : t;
  endfunction

  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= eff_len(trp) - PRE_W'(1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - PRE_W'(1);
    end
  end

  assign expired = run && (cnt == '0);

  // R4: precharge is not cut short by the sequencer
  a_r4_pre_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !expired) |=> run);

endmodule

// File: rtl/drr_sequencer.sv
module drr_sequencer
  import dram_row_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic other_space,
  input  logic cfg_burst_en,
  input  logic cfg_ras_down,
  input  logic ev_refresh,
  input  logic ev_self_refresh,
  input  logic ev_standby,
  input  logic ev_bus_release,
  input  logic ev_clock_stop,
  input  logic row_hit,
  input  logic pre_expired,
  output logic req_ready,
  output logic accept,
  output logic set_valid,
  output logic clr_valid,
  output logic pre_load,
  output logic pre_run,
  output logic col_phase,
  output logic ras_n,
  output logic cas_n,
  output logic addr_sel,
  output logic done
);

  seq_state_e state, state_nx;

  logic hold_mode;
  logic close_evt;
  logic hit_accept;
  logic miss_accept;
  logic row_strobe_on;
  logic next_strobe_on;

  assign hold_mode = keep_open(cfg_burst_en, cfg_ras_down);
  assign close_evt = close_cause(ev_refresh, ev_self_refresh, ev_standby,
                                 ev_bus_release, hold_mode);

  assign req_ready = !other_space && !ev_clock_stop &&
                     ((state == ST_IDLE) || (state == ST_HOLD && !close_evt));
  assign accept      = req_valid && req_ready;
  assign hit_accept  = accept && (state == ST_HOLD) && row_hit;
  assign miss_accept = accept && (state == ST_HOLD) && !row_hit;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (accept) state_nx = ST_ACT;
      ST_HOLD: begin
        if (close_evt)        state_nx = ST_IDLE;
        else if (hit_accept)  state_nx = ST_COL;
        else if (miss_accept) state_nx = ST_PRE;
      end
      ST_PRE:  if (pre_expired) state_nx = ST_ACT;
      ST_ACT:  state_nx = ST_COL;
      ST_COL:  state_nx = (hold_mode && !close_evt) ? ST_HOLD : ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign row_strobe_on  = (state == ST_ACT) || (state == ST_COL) || (state == ST_HOLD);
  assign next_strobe_on = (state_nx == ST_ACT) || (state_nx == ST_COL) || (state_nx == ST_HOLD);

  assign set_valid = (state != ST_ACT) && (state_nx == ST_ACT);
  assign clr_valid = row_strobe_on && !next_strobe_on;
  assign pre_load  = miss_accept;
  assign pre_run   = (state == ST_PRE);
  assign col_phase = (state == ST_COL);

  assign ras_n    = !row_strobe_on;
  assign cas_n    = !col_phase;
  assign addr_sel = col_phase;
  assign done     = col_phase;

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7 / R8: a close cause while holding drops the row strobe
  a_r7_close_drops_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && close_evt) |=> ras_n);
  // R3: a row hit goes straight to the column cycle under a low row strobe
  a_r3_hit_column_only: assert property (@(posedge clk) disable iff (!rst_n)
    hit_accept |=> (!cas_n && !ras_n));
  // R6: other-space traffic does not disturb a held row
  a_r6_other_keeps_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && other_space && !close_evt) |=> !ras_n);
  // R9: clock stop neither closes the row nor lets a request in
  a_r9_clock_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && ev_clock_stop && !close_evt) |=> !ras_n);
  // R2: with keep-open off the row strobe returns high after the column cycle
  a_r2_ras_up: assert property (@(posedge clk) disable iff (!rst_n)
    (col_phase && !hold_mode) |=> ras_n);

endmodule

// File: rtl/dram_row_ctrl.sv
module dram_row_ctrl #(
  parameter int ROW_W = 10,
  parameter int COL_W = 9,
  parameter int PRE_W = 3,
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             other_space,
  input  logic             cfg_burst_en,
  input  logic             cfg_ras_down,
  input  logic [PRE_W-1:0] cfg_precharge,
  input  logic             ev_refresh,
  input  logic             ev_self_refresh,
  input  logic             ev_standby,
  input  logic             ev_bus_release,
  input  logic             ev_clock_stop,
  output logic             req_ready,
  output logic             ras_n,
  output logic             cas_n,
  output logic             addr_sel,
  output logic [AW-1:0]    addr_out,
  output logic             done
);

  logic             accept;
  logic             set_valid;
  logic             clr_valid;
  logic             pre_load;
  logic             pre_run;
  logic             pre_expired;
  logic             col_phase;
  logic             row_hit;
  logic             row_valid;
  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] col_q;

  drr_sequencer u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .other_space     (other_space),
    .cfg_burst_en    (cfg_burst_en),
    .cfg_ras_down    (cfg_ras_down),
    .ev_refresh      (ev_refresh),
    .ev_self_refresh (ev_self_refresh),
    .ev_standby      (ev_standby),
    .ev_bus_release  (ev_bus_release),
    .ev_clock_stop   (ev_clock_stop),
    .row_hit         (row_hit),
    .pre_expired     (pre_expired),
    .req_ready       (req_ready),
    .accept          (accept),
    .set_valid       (set_valid),
    .clr_valid       (clr_valid),
    .pre_load        (pre_load),
    .pre_run         (pre_run),
    .col_phase       (col_phase),
    .ras_n           (ras_n),
    .cas_n           (cas_n),
    .addr_sel        (addr_sel),
    .done            (done)
  );

  drr_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .new_row   (req_row),
    .set_valid (set_valid),
    .clr_valid (clr_valid),
    .open_row  (open_row),
    .row_valid (row_valid),
    .row_hit   (row_hit)
  );

  drr_pre_timer #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pre_load),
    .trp     (cfg_precharge),
    .run     (pre_run),
    .expired (pre_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      col_q <= '0;
    else if (accept) col_q <= req_col;
  end

  function automatic logic [AW-1:0] mux_addr(input logic sel,
                                             input logic [ROW_W-1:0] r,
                                             input logic [COL_W-1:0] c);
    return sel ? AW'(c) : AW'(r);
  endfunction

  assign addr_out = mux_addr(col_phase, open_row, col_q);

  // R7: a high row strobe never coexists with a remembered row
  a_r7_invalid_when_ras_high: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |-> !row_valid);

endmodule

// File: tb/tb_dram_row_ctrl.sv
module tb_dram_row_ctrl;
  localparam int ROW_W = 10;
  localparam int COL_W = 9;
  localparam int PRE_W = 3;
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic other_space = 1'b0;
  logic cfg_burst_en = 1'b0;
  logic cfg_ras_down = 1'b0;
  logic [PRE_W-1:0] cfg_precharge = '0;
  logic ev_refresh = 1'b0, ev_self_refresh = 1'b0, ev_standby = 1'b0;
  logic ev_bus_release = 1'b0, ev_clock_stop = 1'b0;
  logic req_ready, ras_n, cas_n, addr_sel, done;
  logic [AW-1:0] addr_out;

  dram_row_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .PRE_W(PRE_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .req_col(req_col), .other_space(other_space), .cfg_burst_en(cfg_burst_en),
    .cfg_ras_down(cfg_ras_down), .cfg_precharge(cfg_precharge),
    .ev_refresh(ev_refresh), .ev_self_refresh(ev_self_refresh),
    .ev_standby(ev_standby), .ev_bus_release(ev_bus_release),
    .ev_clock_stop(ev_clock_stop), .req_ready(req_ready), .ras_n(ras_n),
    .cas_n(cas_n), .addr_sel(addr_sel), .addr_out(addr_out), .done(done));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct { int col; int acc; int lat; string tag; } exp_t;
  exp_t q[$];

  bit m_open = 0;
  int m_row = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor: pops one expected item for every completion pulse (R10)
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(0, "R10 unexpected done", 1, 0);
      end else begin
        automatic exp_t e = q.pop_front();
        chk(int'(addr_out) == e.col, "R10 column address", int'(addr_out), e.col);
        chk(!cas_n && !ras_n && addr_sel, "R10 strobes at done",
            {ras_n, cas_n, addr_sel}, 3'b001);
        chk((cyc - e.acc) == e.lat, {e.tag, " latency"}, cyc - e.acc, e.lat);
      end
    end
  end

  // driver: one DRAM access, predicted from the requirements
  task automatic access(input int row, input int col, input bit mid_ev, input string tag);
    int p, lat, acts, hic, arow;
    bit hold;
    hold = cfg_burst_en && cfg_ras_down;
    p = (cfg_precharge == 0) ? 1 : int'(cfg_precharge);
    if (m_open && row == m_row) lat = 0;
    else if (m_open)            lat = p + 1;
    else                        lat = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_row = ROW_W'(row);
    req_col = COL_W'(col);
    @(posedge clk);
    #1;
    q.push_back('{col, cyc, lat, tag});
    acts = 0; hic = 0; arow = -1;
    @(negedge clk);
    req_valid = 1'b0;
    if (mid_ev) ev_refresh = 1'b1;
    while (!done) begin
      if (ras_n) hic++;
      else if (cas_n) begin acts++; arow = int'(addr_out); end
      @(negedge clk);
    end
    chk(acts == ((lat == 0) ? 0 : 1), {tag, " activation count"}, acts, (lat == 0) ? 0 : 1);
    chk(hic == ((lat == p + 1) ? p : 0), {tag, " precharge cycles"}, hic, (lat == p + 1) ? p : 0);
    if (acts != 0) chk(arow == row, {tag, " activation row"}, arow, row);
    @(negedge clk);
    chk(ras_n == !(hold && !mid_ev), {tag, " ras after access"}, ras_n, !(hold && !mid_ev));
    ev_refresh = 1'b0;
    m_open = hold && !mid_ev;
    m_row = row;
  endtask

  task automatic close_with(input int which, input string tag);
    @(negedge clk);
    case (which)
      0: ev_refresh = 1'b1;
      1: ev_self_refresh = 1'b1;
      2: ev_standby = 1'b1;
      default: ev_bus_release = 1'b1;
    endcase
    @(negedge clk);
    chk(ras_n == 1'b1, tag, ras_n, 1);
    ev_refresh = 0; ev_self_refresh = 0; ev_standby = 0; ev_bus_release = 0;
    m_open = 0;
  endtask

  initial begin
    #4_000_000;
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && !done && !addr_sel && req_ready, "R1 reset outputs",
        {ras_n, cas_n, done, addr_sel, req_ready}, 5'b11001);

    cfg_burst_en = 1; cfg_ras_down = 1; cfg_precharge = 2;
    access(5, 3, 0, "R5 idle activation");
    access(5, 7, 0, "R3 fast-page hit");
    access(9, 1, 0, "R4 row miss trp=2");

    // R6: other-space traffic while row is held
    @(negedge clk);
    other_space = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!ras_n, "R6 ras held low", ras_n, 0);
      chk(!req_ready, "R6 ready blocked", req_ready, 0);
    end
    other_space = 1'b0;
    access(9, 2, 0, "R6 hit after other space");

    // R9: clock stop keeps the row open
    @(negedge clk);
    ev_clock_stop = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!ras_n, "R9 ras held low", ras_n, 0);
      chk(!req_ready, "R9 ready blocked", req_ready, 0);
    end
    ev_clock_stop = 1'b0;
    access(9, 4, 0, "R9 hit after clock stop");

    cfg_precharge = 0;
    access(3, 6, 0, "R4 row miss trp=0");
    cfg_precharge = 5;
    access(7, 8, 0, "R4 row miss trp=5");

    for (int w = 0; w < 4; w++) begin
      close_with(w, "R7 close event drops ras");
      access(7, 10 + w, 0, "R7 full activation after close");
    end

    // R11: refresh during an access in progress
    access(7, 20, 1, "R11 hit with refresh mid-access");
    access(12, 21, 1, "R11 idle access with refresh mid-access");

    // R8: clearing either bit closes the row
    access(12, 22, 0, "R5 reopen");
    @(negedge clk); cfg_ras_down = 1'b0;
    @(negedge clk); chk(ras_n == 1'b1, "R8 ras_down cleared", ras_n, 1);
    m_open = 0;
    access(12, 23, 0, "R2 ras-up burst only");
    cfg_ras_down = 1'b1;
    access(12, 24, 0, "R5 reopen");
    @(negedge clk); cfg_burst_en = 1'b0;
    @(negedge clk); chk(ras_n == 1'b1, "R8 burst_en cleared", ras_n, 1);
    m_open = 0;
    access(12, 25, 0, "R2 ras_down alone no effect");
    access(12, 26, 0, "R2 no hit in ras-up");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R10 all results seen", q.size(), 0);
    summary();
  end
endmodule